// File: doc/BRIEF.md
# Synchronous Burst SRAM with Flow-Through Reads

This block models a single-port synchronous static memory of the kind that sits beside a processor and its cache controller. Address, strobes, write controls and write data are all captured on the rising clock. Read data is not registered: the word at the address captured by an edge is visible on the read bus during the cycle that follows that edge. One supplied start address can serve a burst of four words. The first word comes from the start address, and an internal two-bit beat counter produces the next three while the advance input is held low. The order of those three is fixed at the start of the burst, either as a wrapping increment of the two low address bits or as those bits XORed with the beat number.

A burst can be started by either of two active-low address strobes. The processor strobe always begins a read, and it is ignored while the chip enable is high. The controller strobe is always honoured and may begin a read or a write. A global write enable writes every lane. Without it, a byte write enable together with one select per lane chooses which lanes are written. Output drive is controlled by an output enable and turns off during writes. A strobe cycle that finds the chip deselected stops the drive from the very next cycle. A sleep input freezes the block. The tristate data bus is split into three parts: an input bus, an output bus and a drive-enable flag. The block is a plain pin-level memory with no handshake, so nothing can apply back-pressure. Every clock edge is one accepted cycle.

Top module: `burst_sram`

## Requirements
- R1: After reset the block is deselected, so `rdata_drive` is 0 until a selected start cycle occurs.
- R2: In a selected read start cycle, `rdata` equals the stored word at the start address during the cycle right after the capturing edge, and `rdata_drive` is 1.
- R3: While `en_n` is high, a low `cpu_strobe_n` is ignored and the running access continues unchanged. A low `ctl_strobe_n` always starts a new cycle, and that cycle is deselected when `en_n` is high.
- R4: With `interleave_sel`=0 at the start edge, each edge with `step_n`=0 and no strobe adds 1 modulo 4 to address bits [1:0] and leaves the upper bits unchanged. For start 5 the sequence is 5,6,7,4,5.
- R5: With `interleave_sel`=1 at the start edge, beat k (k=0..3) uses low bits start[1:0] XOR k. For start 9 the sequence is 9,8,11,10.
- R6: An edge with `step_n`=1 and no accepted strobe keeps the same address, so the same word is read again.
- R7: With `all_wr_n`=0 in a selected cycle other than a processor start, all lanes of the addressed word take `wdata`. This includes burst continuation cycles, which write at the advanced address.
- R8: With `all_wr_n`=1 and `byte_wr_n`=0, only lane i is written, for each lane where `lane_wr_n[i]`=0. Lane i is bits [9i+8:9i]. With both enables high the cycle is a read and nothing is written.
- R9: A processor strobe start cycle is always a read, and any write controls present in that cycle have no effect on memory.
- R10: A strobe cycle with `en_n`=1, `sel_hi`=0 or `sel_lo_n`=1 makes `rdata_drive` 0 from the next cycle until a selected start cycle occurs.
- R11: `rdata_drive` is 0 combinationally while `out_en_n` is 1, and it is 0 in the cycle after any write edge.
- R12: While `sleep` is 1, `rdata_drive` is 0 and edges neither write, load nor advance. After `sleep` falls, the previous address and contents are still in place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the control state (not of the array) |
| addr_i | input | ADDR_W | Start address, captured on a strobe edge |
| cpu_strobe_n | input | 1 | Processor address strobe, active low, starts a read |
| ctl_strobe_n | input | 1 | Cache-controller address strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| interleave_sel | input | 1 | Burst order: 0 wrapping increment, 1 XOR |
| en_n | input | 1 | Chip enable, active low |
| sel_hi | input | 1 | Chip select, active high |
| sel_lo_n | input | 1 | Chip select, active low |
| all_wr_n | input | 1 | Global write enable, active low |
| byte_wr_n | input | 1 | Byte write enable, active low |
| lane_wr_n | input | LANES | Per-lane write selects, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Power-down, active high |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Flow-through read data, zero when not driven |
| rdata_drive | output | 1 | High when the data bus would be driven |

## Verification
The assertions assume that the control inputs are stable around each rising edge and that `interleave_sel` matters only at a start edge. They also assume that `sleep` and `out_en_n` change only between edges, since their effect on drive is combinational. The bench changes every input on the falling edge and samples a quarter period after the rising edge. It reads back only addresses it has written first, so the array never returns unknown data. Burst order is checked only inside one four-beat window after each start, and every deselect case begins with an explicit strobe.

// File: rtl/bsram_pkg.sv
`timescale 1ns/1ps
package bsram_pkg;
  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } order_e;

  function automatic logic [1:0] beat_low(input logic [1:0] start,
                                          input logic [1:0] beat,
                                          input order_e ord);
    return (ord == ORD_XOR) ? (start ^ beat) : (start + beat);
  endfunction
endpackage

// File: rtl/burst_seq.sv
`timescale 1ns/1ps
module burst_seq
  import bsram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  order_e            load_order_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic [ADDR_W-1:0] nxt_addr_o
);
  logic [ADDR_W-1:0] base_q, base_d;
  logic [1:0]        beat_q, beat_d;
  order_e            ord_q, ord_d;

  always_comb begin
    base_d = base_q;
    beat_d = beat_q;
    ord_d  = ord_q;
    if (load_i) begin
      base_d = load_addr_i;
      beat_d = 2'd0;
      ord_d  = load_order_i;
    end else if (step_i) begin
      beat_d = beat_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= 2'd0;
      ord_q  <= ORD_LINEAR;
    end else begin
      base_q <= base_d;
      beat_q <= beat_d;
      ord_q  <= ord_d;
    end
  end

  assign cur_addr_o = {base_q[ADDR_W-1:2], beat_low(base_q[1:0], beat_q, ord_q)};
  assign nxt_addr_o = {base_d[ADDR_W-1:2], beat_low(base_d[1:0], beat_d, ord_d)};

  // R2: a start edge presents the start address itself
  p_load_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> cur_addr_o == $past(load_addr_i));

  // R4: linear advance wraps the low bits, upper bits fixed
  p_linear_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && step_i && ord_q == ORD_LINEAR) |=>
      (cur_addr_o[1:0] == $past(cur_addr_o[1:0]) + 2'd1) &&
      (cur_addr_o[ADDR_W-1:2] == $past(cur_addr_o[ADDR_W-1:2])));

  // R5: XOR advance keeps the upper bits and moves to a new word
  p_xor_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && step_i && ord_q == ORD_XOR) |=>
      (cur_addr_o[1:0] != $past(cur_addr_o[1:0])) &&
      $stable(cur_addr_o[ADDR_W-1:2]));

  // R6: without load or advance the address holds
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !step_i) |=> $stable(cur_addr_o));
endmodule

// File: rtl/lane_sel.sv
`timescale 1ns/1ps
module lane_sel #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             allow_i,
  input  logic             all_wr_n,
  input  logic             byte_wr_n,
  input  logic [LANES-1:0] lane_wr_n,
  output logic [LANES-1:0] mask_o
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign mask_o[i] = allow_i & (~all_wr_n | (~byte_wr_n & ~lane_wr_n[i]));
  end

  // R8: some lane is written only when one of the two enables is asserted
  p_mask_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|mask_o) |-> (!all_wr_n || !byte_wr_n));

  // R7: the global enable reaches every lane of an allowed cycle
  p_global_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (allow_i && !all_wr_n) |-> (&mask_o));
endmodule

// File: rtl/sram_array.sv
`timescale 1ns/1ps
module sram_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        we_mask,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar i = 0; i < LANES; i++) begin : g_bank
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we_mask[i]) mem[waddr] <= wdata[i*LANE_W +: LANE_W];
    end
    assign rdata[i*LANE_W +: LANE_W] = mem[raddr];
  end
endmodule

// File: rtl/burst_sram.sv
`timescale 1ns/1ps
module burst_sram
  import bsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    cpu_strobe_n,
  input  logic                    ctl_strobe_n,
  input  logic                    step_n,
  input  logic                    interleave_sel,
  input  logic                    en_n,
  input  logic                    sel_hi,
  input  logic                    sel_lo_n,
  input  logic                    all_wr_n,
  input  logic                    byte_wr_n,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic                    out_en_n,
  input  logic                    sleep,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdata_drive
);
  localparam int DATA_W = LANES * LANE_W;

  logic              cpu_start, load, sel_now, next_active, advance, write_go;
  logic              active_q, wr_q;
  logic [LANES-1:0]  mask;
  logic [ADDR_W-1:0] cur_addr, nxt_addr;
  logic [DATA_W-1:0] raw;
  order_e            order_in;

  assign cpu_start   = ~sleep & ~cpu_strobe_n & ~en_n;
  assign load        = cpu_start | (~sleep & ~ctl_strobe_n);
  assign sel_now     = ~en_n & sel_hi & ~sel_lo_n;
  assign next_active = load ? sel_now : active_q;
  assign advance     = ~sleep & active_q & ~step_n;
  assign order_in    = interleave_sel ? ORD_XOR : ORD_LINEAR;

  burst_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (load),
    .load_addr_i  (addr_i),
    .load_order_i (order_in),
    .step_i       (advance),
    .cur_addr_o   (cur_addr),
    .nxt_addr_o   (nxt_addr)
  );

  lane_sel #(.LANES(LANES)) u_lanes (
    .clk       (clk),
    .rst_n     (rst_n),
    .allow_i   (~sleep & ~cpu_start & next_active),
    .all_wr_n  (all_wr_n),
    .byte_wr_n (byte_wr_n),
    .lane_wr_n (lane_wr_n),
    .mask_o    (mask)
  );

  assign write_go = |mask;

  sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk     (clk),
    .we_mask (mask),
    .waddr   (nxt_addr),
    .wdata   (wdata),
    .raddr   (cur_addr),
    .rdata   (raw)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      wr_q     <= 1'b0;
    end else if (!sleep) begin
      active_q <= next_active;
      wr_q     <= write_go;
    end
  end

  assign rdata_drive = active_q & ~wr_q & ~out_en_n & ~sleep;
  assign rdata       = rdata_drive ? raw : '0;

  // R10: a deselecting strobe cycle silences the bus from the next cycle
  p_deselect_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !sel_now) |=> !rdata_drive);

  // R11: output enable high never drives
  p_oe_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> !rdata_drive);

  // R11: the cycle after a write edge does not drive
  p_write_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    write_go |=> !rdata_drive);

  // R12: sleep freezes the selection state and the address
  p_sleep_freeze_r12: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> $stable(active_q) && $stable(cur_addr));

  // R9: a processor start never writes
  p_cpu_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_start |-> !write_go);
endmodule

// File: tb/burst_sram_test.sv
`timescale 1ns/1ps
module burst_sram_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int DW = NL * LW;

  localparam int K_SKIP = 0;
  localparam int K_OFF  = 1;
  localparam int K_DATA = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic cpu_strobe_n = 1'b1, ctl_strobe_n = 1'b1, step_n = 1'b1, interleave_sel = 1'b0;
  logic en_n = 1'b0, sel_hi = 1'b1, sel_lo_n = 1'b0;
  logic all_wr_n = 1'b1, byte_wr_n = 1'b1;
  logic [NL-1:0] lane_wr_n = '1;
  logic out_en_n = 1'b0, sleep = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic rdata_drive;

  // staged next-cycle values
  logic [AW-1:0] n_addr;
  logic n_cpu, n_ctl, n_step, n_ilv, n_en, n_shi, n_slo, n_all, n_byte, n_oe, n_sleep;
  logic [NL-1:0] n_lane;
  logic [DW-1:0] n_wdata;

  logic [DW-1:0] model [64];
  int q_kind [$];
  logic [DW-1:0] q_data [$];
  string q_tag [$];
  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) uut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i),
    .cpu_strobe_n(cpu_strobe_n), .ctl_strobe_n(ctl_strobe_n), .step_n(step_n),
    .interleave_sel(interleave_sel), .en_n(en_n), .sel_hi(sel_hi), .sel_lo_n(sel_lo_n),
    .all_wr_n(all_wr_n), .byte_wr_n(byte_wr_n), .lane_wr_n(lane_wr_n),
    .out_en_n(out_en_n), .sleep(sleep), .wdata(wdata),
    .rdata(rdata), .rdata_drive(rdata_drive)
  );

  function automatic logic [DW-1:0] pat(input int a);
    logic [31:0] v;
    v = 32'(a) * 32'h0103_0507 + 32'h1111_0000;
    return {4'h9, v};
  endfunction

  task automatic idle_n();
    n_addr = '0; n_cpu = 1; n_ctl = 1; n_step = 1; n_ilv = 0;
    n_en = 0; n_shi = 1; n_slo = 0; n_all = 1; n_byte = 1;
    n_lane = '1; n_oe = 0; n_sleep = 0; n_wdata = '0;
  endtask

  task automatic mwrite(input int a, input logic [DW-1:0] d, input logic [NL-1:0] m);
    for (int i = 0; i < NL; i++)
      if (m[i]) model[a][i*LW +: LW] = d[i*LW +: LW];
  endtask

  // driver: applies staged inputs at the falling edge and queues the expectation
  task automatic go(input int kind, input int a, input string tag);
    @(negedge clk);
    addr_i = n_addr; cpu_strobe_n = n_cpu; ctl_strobe_n = n_ctl; step_n = n_step;
    interleave_sel = n_ilv; en_n = n_en; sel_hi = n_shi; sel_lo_n = n_slo;
    all_wr_n = n_all; byte_wr_n = n_byte; lane_wr_n = n_lane;
    out_en_n = n_oe; sleep = n_sleep; wdata = n_wdata;
    q_kind.push_back(kind);
    q_data.push_back(model[a]);
    q_tag.push_back(tag);
  endtask

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops one expectation per cycle, a quarter period after the edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (q_kind.size() > 0) begin
        int k;
        logic [DW-1:0] d;
        string t;
        k = q_kind.pop_front();
        d = q_data.pop_front();
        t = q_tag.pop_front();
        if (k == K_OFF)
          check(rdata_drive == 1'b0, t, {35'd0, rdata_drive}, '0);
        else if (k == K_DATA)
          check(rdata_drive && rdata == d, t, rdata, d);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) model[i] = '0;
    idle_n();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    check(rdata_drive == 1'b0, "R1 reset", {35'd0, rdata_drive}, '0);
    go(K_OFF, 0, "R1 idle after reset");

    // R7: fill 0..31 with global writes
    for (int a = 0; a < 32; a++) begin
      idle_n(); n_ctl = 0; n_addr = AW'(a); n_all = 0; n_wdata = pat(a);
      go(K_OFF, 0, "R11 write quiet");
      mwrite(a, pat(a), '1);
    end

    // R2/R4: linear burst from 5
    idle_n(); n_ctl = 0; n_addr = 6'd5;
    go(K_DATA, 5, "R2 start read");
    idle_n(); n_step = 0; go(K_DATA, 6, "R4 beat1");
    go(K_DATA, 7, "R4 beat2");
    go(K_DATA, 4, "R4 beat3");
    go(K_DATA, 5, "R4 wrap");
    // R6: hold
    idle_n(); go(K_DATA, 5, "R6 hold");
    go(K_DATA, 5, "R6 hold again");

    // R5: interleaved burst from 9
    idle_n(); n_ctl = 0; n_addr = 6'd9; n_ilv = 1;
    go(K_DATA, 9, "R5 beat0");
    idle_n(); n_step = 0;
    go(K_DATA, 8, "R5 beat1");
    go(K_DATA, 11, "R5 beat2");
    go(K_DATA, 10, "R5 beat3");

    // R9: processor start with write controls is a read
    idle_n(); n_cpu = 0; n_addr = 6'd12; n_all = 0; n_wdata = 36'hF_DEAD_BEEF;
    go(K_DATA, 12, "R9 cpu read");
    idle_n(); go(K_DATA, 12, "R9 memory untouched");

    // R3: processor strobe ignored with en_n high
    idle_n(); n_cpu = 0; n_en = 1; n_addr = 6'd3;
    go(K_DATA, 12, "R3 cpu strobe ignored");

    // R10/R3: controller strobe honoured while deselected
    idle_n(); n_ctl = 0; n_en = 1; n_addr = 6'd3;
    go(K_OFF, 0, "R3 ctl strobe deselects");
    idle_n(); go(K_OFF, 0, "R10 stays off");
    idle_n(); n_ctl = 0; n_shi = 0; n_addr = 6'd3;
    go(K_OFF, 0, "R10 sel_hi low");
    idle_n(); n_ctl = 0; n_slo = 1; n_addr = 6'd3;
    go(K_OFF, 0, "R10 sel_lo_n high");
    idle_n(); n_ctl = 0; n_addr = 6'd3;
    go(K_DATA, 3, "R10 reselect");

    // R8: byte writes on lanes 0 and 2
    idle_n(); n_ctl = 0; n_addr = 6'd2; n_byte = 0; n_lane = 4'b1010;
    n_wdata = 36'hA_BCDE_F012;
    go(K_OFF, 0, "R8 byte write");
    mwrite(2, 36'hA_BCDE_F012, 4'b0101);
    idle_n(); n_ctl = 0; n_addr = 6'd2;
    go(K_DATA, 2, "R8 merged lanes");
    idle_n(); n_ctl = 0; n_addr = 6'd2; n_lane = '0; n_wdata = 36'h3_3333_3333;
    go(K_DATA, 2, "R8 no enable no write");
    idle_n(); go(K_DATA, 2, "R8 still unchanged");

    // R7: burst write from 20
    idle_n(); n_ctl = 0; n_addr = 6'd20; n_all = 0; n_wdata = 36'h1_2000_0000;
    go(K_OFF, 0, "R7 burst write0");
    mwrite(20, 36'h1_2000_0000, '1);
    for (int b = 1; b < 4; b++) begin
      idle_n(); n_step = 0; n_all = 0; n_wdata = 36'h1_2000_0000 + 36'(b);
      go(K_OFF, 0, "R7 burst write");
      mwrite(20 + b, 36'h1_2000_0000 + 36'(b), '1);
    end
    idle_n(); n_ctl = 0; n_addr = 6'd20;
    go(K_DATA, 20, "R7 read beat0");
    idle_n(); n_step = 0;
    go(K_DATA, 21, "R7 read beat1");
    go(K_DATA, 22, "R7 read beat2");
    go(K_DATA, 23, "R7 read beat3");

    // R11: output enable
    idle_n(); n_oe = 1; go(K_OFF, 0, "R11 oe high");
    idle_n(); go(K_DATA, 23, "R11 oe low");

    // R12: sleep
    idle_n(); n_sleep = 1; n_ctl = 0; n_addr = 6'd0; n_all = 0; n_wdata = 36'h7_7777_7777;
    go(K_OFF, 0, "R12 sleep off");
    idle_n(); n_sleep = 1; n_step = 0;
    go(K_OFF, 0, "R12 sleep no advance");
    idle_n(); go(K_DATA, 23, "R12 address kept");
    idle_n(); n_ctl = 0; n_addr = 6'd0;
    go(K_DATA, 0, "R12 contents kept");

    idle_n();
    go(K_SKIP, 0, "drain");
    go(K_SKIP, 0, "drain");
    repeat (2) @(posedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule